// File: doc/BRIEF.md
# Fuse Key Register-Readout Controller

This block lets software read 32-bit words out of a one-time-programmable key array by issuing commands through a control register. The key array is not mapped into the address space. Software writes a control word that holds a byte offset, an unlock code and a start bit. The controller then asks a behavioural fuse-array model for the addressed word. The model answers after a fixed latency. The controller stores the answer in a result register, and then drops the start bit. Software polls that bit to learn that the read is complete.

The register port accepts every access in the cycle in which `bus_valid` is high. There is no back-pressure at this port, and read data is returned combinationally in the same cycle. Inside the block, the link between the controller and the fuse model uses a valid/ready request channel and a valid/ready response channel. The model only takes a request when it is idle. It holds its response valid and stable until the controller takes it.

After software has read the result, it writes zero to the control register. This releases the lock and returns the register to its idle value.

Top module: `fuse_key_rdctl`

## Requirements
- R1: After reset, the control register and the result register both read as zero.
- R2: The control register is at byte address 0x40 and the result register is at byte address 0x60. A control read returns the offset in bits [24:16], the lock code in bits [15:8] and the start bit in bit 1; every other bit reads zero. Any other address reads zero. A write to any address other than 0x40 changes nothing.
- R3: A read begins when a control write sets bit 1 and carries 0xAC in bits [15:8]. The start bit then reads as one until the read is finished.
- R4: Call the clock edge that captures the start command edge 0. The result register holds the new word after edge 9. The start bit reads zero after edge 10. The fuse model answers 8 cycles after it accepts the request.
- R5: The word fetched for byte offset `o` is ((o[8:2] + 1) * 0x9E3779B9) mod 2^32. Offset bits [1:0] are ignored by the fetch, but the control register keeps them as written.
- R6: An offset of 0x100 or above returns zero in the result register.
- R7: A start command whose bits [15:8] are not 0xAC is dropped. The start bit reads zero in the very next cycle and the result register keeps its value. The offset and lock fields are stored as written.
- R8: While a read is in flight, writes to the control register are ignored, including a write of zero. Reads of the result register during this time return the previous word.
- R9: When no read is in flight, writing zero to the control register makes it read zero and leaves the result register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Register access strobe; always accepted |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |

## Verification
Directed commands cover several access patterns:
- offset zero, an unaligned offset, the last in-range word, and offsets at and above the end of the key area;
- a good command, a bad unlock code, and control writes that land while a fetch is in flight.

Together these separate several faults: a wrong word index, a missing range clamp, a start bit that clears too early or too late, and a lock check that lets bad codes through. A seeded random run then mixes offsets across the whole 9-bit range with an occasional wrong unlock code and occasional release writes. This exposes any state that leaks from one command into the next.

// File: rtl/fuse_rdctl_pkg.sv
package fuse_rdctl_pkg;
  localparam int CTRL_OFS  = 'h40;
  localparam int RES_OFS   = 'h60;
  localparam int OFF_LSB   = 16;
  localparam int LOCK_LSB  = 8;
  localparam int START_BIT = 1;
  localparam logic [7:0] UNLOCK_CODE = 8'hAC;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } rd_state_e;

  // Behavioural fuse contents, computed from the word index
  function automatic logic [31:0] fuse_pattern(input logic [31:0] widx);
    return (widx + 32'd1) * 32'h9E37_79B9;
  endfunction
endpackage

// File: rtl/fuse_array_model.sv
module fuse_array_model
  import fuse_rdctl_pkg::*;
#(
  parameter int KEY_BYTES = 256,
  parameter int OFF_W     = 9,
  parameter int LAT       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [OFF_W-1:0] req_off,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [31:0]      rsp_data
);
  localparam int CNT_W = $clog2(LAT + 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OFF_W-1:0] off_q;

  assign req_ready = !busy_q;
  assign rsp_valid = busy_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      off_q  <= '0;
    end else if (req_valid && req_ready) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(LAT - 1);
      off_q  <= req_off;
    end else if (busy_q) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      else if (rsp_ready) busy_q <= 1'b0;
    end
  end

  always_comb begin
    if (32'(off_q) < KEY_BYTES) rsp_data = fuse_pattern(32'(off_q[OFF_W-1:2]));
    else                        rsp_data = '0;
  end

  // R4
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
endmodule

// File: rtl/rdctl_fsm.sv
module rdctl_fsm
  import fuse_rdctl_pkg::*;
#(
  parameter int KEY_BYTES = 256,
  parameter int OFF_W     = 9,
  parameter int LAT       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [OFF_W-1:0] cmd_off,
  output logic             busy,
  output logic             fetch_valid,
  input  logic             fetch_ready,
  output logic [OFF_W-1:0] fetch_off,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [31:0]      rsp_data,
  output logic             cap_we,
  output logic [31:0]      cap_data,
  output logic             start_clr
);
  rd_state_e        state_q, state_d;
  logic [OFF_W-1:0] off_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (go) state_d = ST_FETCH;
      ST_FETCH: if (fetch_ready) state_d = ST_WAIT;
      ST_WAIT:  if (rsp_valid) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      off_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && go) off_q <= cmd_off;
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign fetch_valid = (state_q == ST_FETCH);
  assign fetch_off   = {off_q[OFF_W-1:2], 2'b00};
  assign rsp_ready   = (state_q == ST_WAIT);
  assign cap_we      = (state_q == ST_WAIT) && rsp_valid;
  assign cap_data    = rsp_data;
  assign start_clr   = (state_q == ST_DONE);

  logic [15:0] wait_cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wait_cyc_q <= '0;
    else if (state_q != ST_WAIT) wait_cyc_q <= '0;
    else                        wait_cyc_q <= wait_cyc_q + 16'd1;
  end

  // R4
  fetch_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_we |-> wait_cyc_q == 16'(LAT - 1));

  // R6
  out_of_range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_we && (32'(off_q) >= KEY_BYTES) |-> cap_data == 32'd0);
endmodule

// File: rtl/rdctl_regs.sv
module rdctl_regs
  import fuse_rdctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              busy,
  input  logic              start_clr,
  input  logic              cap_we,
  input  logic [31:0]       cap_data,
  output logic              go,
  output logic [OFF_W-1:0]  cmd_off
);
  logic [OFF_W-1:0] off_q;
  logic [7:0]       lock_q;
  logic             start_q;
  logic [31:0]      res_q;
  logic             hit_ctrl, hit_res, ctrl_wr, accept;
  logic [31:0]      ctrl_word;

  assign hit_ctrl = (bus_addr == ADDR_W'(CTRL_OFS));
  assign hit_res  = (bus_addr == ADDR_W'(RES_OFS));
  assign ctrl_wr  = bus_valid && bus_wr && hit_ctrl;
  assign accept   = ctrl_wr && !busy;
  assign go       = accept && bus_wdata[START_BIT] &&
                    (bus_wdata[LOCK_LSB +: 8] == UNLOCK_CODE);
  assign cmd_off  = bus_wdata[OFF_LSB +: OFF_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q   <= '0;
      lock_q  <= '0;
      start_q <= 1'b0;
      res_q   <= '0;
    end else begin
      if (accept) begin
        off_q   <= bus_wdata[OFF_LSB +: OFF_W];
        lock_q  <= bus_wdata[LOCK_LSB +: 8];
        start_q <= go;
      end else if (start_clr) begin
        start_q <= 1'b0;
      end
      if (cap_we) res_q <= cap_data;
    end
  end

  always_comb begin
    ctrl_word                   = '0;
    ctrl_word[OFF_LSB +: OFF_W] = off_q;
    ctrl_word[LOCK_LSB +: 8]    = lock_q;
    ctrl_word[START_BIT]        = start_q;
    if (!bus_valid || bus_wr) bus_rdata = '0;
    else if (hit_ctrl)        bus_rdata = ctrl_word;
    else if (hit_res)         bus_rdata = res_q;
    else                      bus_rdata = '0;
  end

  // R8
  busy_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ctrl_wr |=> $stable(off_q) && $stable(lock_q));

  // R7
  bad_lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !busy && bus_wdata[START_BIT] &&
    (bus_wdata[LOCK_LSB +: 8] != UNLOCK_CODE) |=> !start_q && $stable(res_q));

  // R8
  res_only_on_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_q) |-> $past(cap_we));

  // R3
  start_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q && !start_clr |=> start_q);
endmodule

// File: rtl/fuse_key_rdctl.sv
module fuse_key_rdctl
  import fuse_rdctl_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int OFF_W     = 9,
  parameter int KEY_BYTES = 256,
  parameter int LAT       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  logic             busy, go, start_clr, cap_we;
  logic [31:0]      cap_data, rsp_data;
  logic [OFF_W-1:0] cmd_off, fetch_off;
  logic             fetch_valid, fetch_ready, rsp_valid, rsp_ready;

  rdctl_regs #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_regs (
    .clk, .rst_n, .bus_valid, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .busy, .start_clr, .cap_we, .cap_data, .go, .cmd_off
  );

  rdctl_fsm #(.KEY_BYTES(KEY_BYTES), .OFF_W(OFF_W), .LAT(LAT)) u_fsm (
    .clk, .rst_n, .go, .cmd_off, .busy, .fetch_valid, .fetch_ready,
    .fetch_off, .rsp_valid, .rsp_ready, .rsp_data, .cap_we, .cap_data,
    .start_clr
  );

  fuse_array_model #(.KEY_BYTES(KEY_BYTES), .OFF_W(OFF_W), .LAT(LAT)) u_fuse (
    .clk, .rst_n, .req_valid(fetch_valid), .req_ready(fetch_ready),
    .req_off(fetch_off), .rsp_valid, .rsp_ready, .rsp_data
  );
endmodule

// File: tb/fuse_key_rdctl_tb.sv
`timescale 1ns/1ps
module fuse_key_rdctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  int n_chk = 0;
  int n_err = 0;
  logic [31:0] exp_res = '0;

  always #2.5 clk = ~clk;

  fuse_key_rdctl u_dut (.clk, .rst_n, .bus_valid, .bus_wr, .bus_addr,
                        .bus_wdata, .bus_rdata);

  function automatic logic [31:0] key_word(input logic [8:0] off);
    if (off >= 9'h100) return 32'd0;
    return (32'(off[8:2]) + 32'd1) * 32'h9E37_79B9;
  endfunction

  function automatic logic [31:0] cmd(input logic [8:0] off, input logic [7:0] lk,
                                      input logic st);
    return (32'(off) << 16) | (32'(lk) << 8) | (32'(st) << 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #0.1;
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 40; i++) begin
      rd(8'h40, v);
      if (!v[1]) break;
      @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset values
    rd(8'h40, v); check("R1 ctrl", v, 32'd0);
    rd(8'h60, v); check("R1 result", v, 32'd0);

    // R3 R4 R5 offset 0 with exact timing
    wr(8'h40, cmd(9'h000, 8'hAC, 1'b1));
    rd(8'h40, v); check("R3 start set", v, cmd(9'h000, 8'hAC, 1'b1));
    repeat (8) @(posedge clk); #1;
    rd(8'h60, v); check("R4 result not yet at edge 8", v, 32'd0);
    @(posedge clk); #1;
    rd(8'h60, v); check("R4 result at edge 9", v, key_word(9'h000));
    rd(8'h40, v); check("R4 start still set at edge 9", v[1], 1'b1);
    @(posedge clk); #1;
    rd(8'h40, v); check("R4 start clear at edge 10", v, cmd(9'h000, 8'hAC, 1'b0));
    exp_res = key_word(9'h000);

    // R9 release
    wr(8'h40, 32'd0);
    rd(8'h40, v); check("R9 ctrl released", v, 32'd0);
    rd(8'h60, v); check("R9 result kept", v, exp_res);

    // R2 other addresses
    wr(8'h60, 32'hDEAD_BEEF);
    rd(8'h60, v); check("R2 result not writable", v, exp_res);
    wr(8'h44, cmd(9'h004, 8'hAC, 1'b1));
    rd(8'h40, v); check("R2 stray write no effect", v, 32'd0);
    rd(8'h00, v); check("R2 unmapped reads zero", v, 32'd0);

    // R5 unaligned offset
    wr(8'h40, cmd(9'h00A, 8'hAC, 1'b1));
    wait_idle();
    exp_res = key_word(9'h008);
    rd(8'h60, v); check("R5 unaligned offset", v, exp_res);
    rd(8'h40, v); check("R5 ctrl keeps low bits", v, cmd(9'h00A, 8'hAC, 1'b0));

    // R5 last in-range word
    wr(8'h40, cmd(9'h0FC, 8'hAC, 1'b1));
    wait_idle();
    exp_res = key_word(9'h0FC);
    rd(8'h60, v); check("R5 last word", v, exp_res);

    // R6 out of range
    wr(8'h40, cmd(9'h100, 8'hAC, 1'b1));
    wait_idle();
    rd(8'h60, v); check("R6 offset 0x100", v, 32'd0);
    wr(8'h40, cmd(9'h010, 8'hAC, 1'b1));
    wait_idle();
    wr(8'h40, cmd(9'h1FC, 8'hAC, 1'b1));
    wait_idle();
    rd(8'h60, v); check("R6 offset 0x1FC", v, 32'd0);
    exp_res = 32'd0;

    // R7 bad lock
    wr(8'h40, cmd(9'h020, 8'hAC, 1'b1));
    wait_idle();
    exp_res = key_word(9'h020);
    wr(8'h40, cmd(9'h040, 8'h55, 1'b1));
    rd(8'h40, v); check("R7 bad lock start cleared", v, cmd(9'h040, 8'h55, 1'b0));
    repeat (12) @(posedge clk); #1;
    rd(8'h60, v); check("R7 bad lock result kept", v, exp_res);

    // R8 writes during fetch
    wr(8'h40, cmd(9'h030, 8'hAC, 1'b1));
    repeat (2) @(posedge clk); #1;
    rd(8'h60, v); check("R8 result old during fetch", v, exp_res);
    wr(8'h40, cmd(9'h0C0, 8'hAC, 1'b1));
    wr(8'h40, 32'd0);
    rd(8'h40, v); check("R8 ctrl unchanged while busy", v, cmd(9'h030, 8'hAC, 1'b1));
    wait_idle();
    exp_res = key_word(9'h030);
    rd(8'h60, v); check("R8 first command wins", v, exp_res);
    rd(8'h40, v); check("R8 ctrl after fetch", v, cmd(9'h030, 8'hAC, 1'b0));

    // Random mix R3 R5 R6 R7 R9
    for (int n = 0; n < 60; n++) begin
      logic [8:0] off;
      logic       good;
      off  = 9'($urandom);
      good = ($urandom % 4) != 0;
      wr(8'h40, cmd(off, good ? 8'hAC : 8'h3C, 1'b1));
      if (good) begin
        wait_idle();
        exp_res = key_word(off);
        rd(8'h40, v); check("R3 random ctrl", v, cmd(off, 8'hAC, 1'b0));
      end else begin
        rd(8'h40, v); check("R7 random bad lock", v, cmd(off, 8'h3C, 1'b0));
      end
      rd(8'h60, v); check("R5 random result", v, exp_res);
      if ($urandom % 3 == 0) begin
        wr(8'h40, 32'd0);
        rd(8'h40, v); check("R9 random release", v, 32'd0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule